// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a NOR-style flash array. An external host drives a chip-enable, write-enable and output-enable bus with an address and a 16-bit data word. Every bus signal is brought into the controller's clock domain through a short synchronizer. A write takes effect when its window closes: the window is open while chip enable and write enable are both low, and it closes at whichever of the two rises first. A window during which output enable was also low is thrown away.

The low byte of each accepted write is a command. Single-cycle commands choose what a read returns: array data, the identifier words or the status byte. Another single-cycle command clears the error flags. Block erase and word program are two-cycle sequences. Each one hands a start pulse, an address and a data word to the array side, which answers with a done pulse. A suspend command freezes the running operation through a hold level, and a confirm command releases it.

The state machine has five named states:
- `ST_IDLE`: no operation is set up.
- `ST_ERS_SETUP`: an erase opener has been received.
- `ST_PGM_SETUP`: a program opener has been received.
- `ST_BUSY`: an operation is running.
- `ST_SUSP`: an operation is suspended.

Its transitions:
- erase opener: IDLE to ERS_SETUP
- program opener: IDLE to PGM_SETUP
- confirm: ERS_SETUP to BUSY
- abort: ERS_SETUP to IDLE
- data word: PGM_SETUP to BUSY
- done: BUSY to IDLE
- suspend: BUSY to SUSP
- resume: SUSP to BUSY

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is idle with reads sourced from the array, `arr_start` and `arr_hold` are low, and the status byte is 0x80. `rdata` is 0 whenever no read is active (a read is active when `ce_n` and `oe_n` are low and `we_n` is high).
- R2: A write is accepted once, with the address and data present when the first of `ce_n` or `we_n` rises. Changes to the bus after that edge have no effect. A write window during which `oe_n` was low is ignored.
- R3: Command 0xFF (in `wdata[7:0]`) makes reads return `arr_rdata` for the read address presented on `arr_raddr`.
- R4: Command 0x90 selects identifier reads. Address 0 returns `MFG_ID`, address 1 returns `DEV_ID`, and any other address returns 0.
- R5: Command 0x70 selects status reads. The status byte is laid out as follows: bit 7 ready, bit 6 erase suspended, bit 5 erase or sequence error, bit 4 program or sequence error, bit 2 program suspended, and all other bits 0.
- R6: Command 0x50 clears status bits 5 and 4 and does not change the read source.
- R7: The sequence 0x20 then 0xD0 pulses `arr_start` for one cycle with `arr_erase` high and `arr_addr` equal to the second write's address. It switches reads to status, and status bit 7 reads 0 while the operation runs.
- R8: The sequence 0x40 or 0x10, followed by a data word, pulses `arr_start` with `arr_erase` low. `arr_addr` and `arr_wdata` take the second write's address and data, and reads switch to status.
- R9: If the second write of an erase sequence is not 0xD0, no operation starts, status bits 5 and 4 are set, and reads switch to status.
- R10: Command 0xB0 while busy raises `arr_hold`. Status then reads ready, with bit 6 set for an erase or bit 2 set for a program. While suspended, 0xFF gives array reads. 0xD0 lowers `arr_hold`, returns status to busy and clears the suspend bit.
- R11: In idle, any code outside 0xFF, 0x90, 0x70, 0x50, 0x20, 0x40 and 0x10 is ignored: no start, and the read source and status are unchanged.
- R12: On `arr_done` the controller returns to idle, status bit 7 reads 1, and reads stay on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Bus chip enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| addr | input | AW | Bus address |
| wdata | input | 16 | Bus write data; low byte carries commands |
| rdata | output | 16 | Read data returned to the bus |
| arr_raddr | output | AW | Synchronized read address sent to the array |
| arr_rdata | input | 16 | Array word for `arr_raddr` |
| arr_start | output | 1 | One-cycle operation start pulse |
| arr_erase | output | 1 | Operation kind: 1 erase, 0 program |
| arr_addr | output | AW | Operation address |
| arr_wdata | output | 16 | Program data |
| arr_hold | output | 1 | Suspend level to the array |
| arr_done | input | 1 | One-cycle completion pulse from the array |

## Verification
The bench builds the controller with a 12-bit address, the default two-stage synchronizer and two distinct identifier words, so that a mix-up between manufacturer and device codes shows in the read data. Its array stub completes an operation after 60 unheld cycles. That window is long enough for a status read, a suspend, an array read while suspended and a resume to happen in the middle of an erase and of a program. The bench also drives write windows that close on chip enable first and then change the bus, as well as windows that overlap output enable.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERS_SETUP,
        ST_PGM_SETUP,
        ST_BUSY,
        ST_SUSP
    } ctl_state_t;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_ID,
        RD_STATUS
    } rd_src_t;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_PROG_A     = 8'h40;
    localparam logic [7:0] CMD_PROG_B     = 8'h10;
    localparam logic [7:0] CMD_SUSPEND    = 8'hB0;

    function automatic logic idle_cmd_known(input logic [7:0] c);
        return (c == CMD_READ_ARRAY) || (c == CMD_READ_ID) ||
               (c == CMD_READ_STAT)  || (c == CMD_CLR_STAT) ||
               (c == CMD_ERASE)      || (c == CMD_PROG_A)   ||
               (c == CMD_PROG_B);
    endfunction

endpackage

// File: rtl/fcc_bus_sync.sv
module fcc_bus_sync #(
    parameter int AW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [15:0]   wr_data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr
);
    localparam int CW = 3 + AW + 16;
    localparam logic [CW-1:0] RST_V = {3'b111, {(AW + 16){1'b0}}};

    logic [CW-1:0] pipe [SYNC_STAGES];
    logic [CW-1:0] s;
    logic          ce_s, we_s, oe_s, active;
    logic          act_q, bad_q;
    logic [AW-1:0] cap_addr;
    logic [15:0]   cap_data;

    // all bus bits travel together so control and data stay aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= RST_V;
        end else begin
            pipe[0] <= {ce_n, we_n, oe_n, addr, wdata};
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign s      = pipe[SYNC_STAGES-1];
    assign ce_s   = s[CW-1];
    assign we_s   = s[CW-2];
    assign oe_s   = s[CW-3];
    assign active = !ce_s && !we_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            bad_q    <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            act_q <= active;
            bad_q <= active ? (bad_q || !oe_s) : 1'b0;
            if (active) begin
                cap_addr <= s[AW+15:16];
                cap_data <= s[15:0];
            end
        end
    end

    assign wr_stb  = act_q && !active && !bad_q;
    assign wr_addr = cap_addr;
    assign wr_data = cap_data;
    assign rd_en   = !ce_s && !oe_s && we_s;
    assign rd_addr = s[AW+15:16];

    p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/fcc_ctrl_fsm.sv
module fcc_ctrl_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    input  logic          arr_done,
    output rd_src_t       rd_src,
    output logic [7:0]    status,
    output logic          arr_start,
    output logic          arr_erase,
    output logic [AW-1:0] arr_addr,
    output logic [15:0]   arr_wdata,
    output logic          arr_hold
);
    ctl_state_t state, nxt;
    logic [7:0] cmd;
    logic       err_ers, err_pgm;

    assign cmd = wr_data[7:0];

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (wr_stb) begin
                if (cmd == CMD_ERASE) nxt = ST_ERS_SETUP;
                else if (cmd == CMD_PROG_A || cmd == CMD_PROG_B) nxt = ST_PGM_SETUP;
            end
            ST_ERS_SETUP: if (wr_stb) nxt = (cmd == CMD_CONFIRM) ? ST_BUSY : ST_IDLE;
            ST_PGM_SETUP: if (wr_stb) nxt = ST_BUSY;
            ST_BUSY: begin
                if (arr_done) nxt = ST_IDLE;
                else if (wr_stb && cmd == CMD_SUSPEND) nxt = ST_SUSP;
            end
            ST_SUSP: if (wr_stb && cmd == CMD_CONFIRM) nxt = ST_BUSY;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_src    <= RD_ARRAY;
            err_ers   <= 1'b0;
            err_pgm   <= 1'b0;
            arr_start <= 1'b0;
            arr_erase <= 1'b0;
            arr_addr  <= '0;
            arr_wdata <= '0;
            arr_hold  <= 1'b0;
        end else begin
            arr_start <= 1'b0;
            unique case (state)
                ST_IDLE: if (wr_stb) begin
                    case (cmd)
                        CMD_READ_ARRAY: rd_src <= RD_ARRAY;
                        CMD_READ_ID:    rd_src <= RD_ID;
                        CMD_READ_STAT:  rd_src <= RD_STATUS;
                        CMD_CLR_STAT: begin
                            err_ers <= 1'b0;
                            err_pgm <= 1'b0;
                        end
                        default: ;
                    endcase
                end
                ST_ERS_SETUP: if (wr_stb) begin
                    rd_src <= RD_STATUS;
                    if (cmd == CMD_CONFIRM) begin
                        arr_start <= 1'b1;
                        arr_erase <= 1'b1;
                        arr_addr  <= wr_addr;
                    end else begin
                        err_ers <= 1'b1;
                        err_pgm <= 1'b1;
                    end
                end
                ST_PGM_SETUP: if (wr_stb) begin
                    rd_src    <= RD_STATUS;
                    arr_start <= 1'b1;
                    arr_erase <= 1'b0;
                    arr_addr  <= wr_addr;
                    arr_wdata <= wr_data;
                end
                ST_BUSY: if (wr_stb && !arr_done) begin
                    if (cmd == CMD_SUSPEND) arr_hold <= 1'b1;
                    if (cmd == CMD_SUSPEND || cmd == CMD_READ_STAT) rd_src <= RD_STATUS;
                end
                ST_SUSP: if (wr_stb) begin
                    case (cmd)
                        CMD_CONFIRM: begin
                            arr_hold <= 1'b0;
                            rd_src   <= RD_STATUS;
                        end
                        CMD_READ_ARRAY: rd_src <= RD_ARRAY;
                        CMD_READ_STAT:  rd_src <= RD_STATUS;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign status = {state != ST_BUSY, arr_hold && arr_erase, err_ers, err_pgm,
                     1'b0, arr_hold && !arr_erase, 2'b00};

    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> (state == ST_BUSY));
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERS_SETUP && wr_stb && cmd != CMD_CONFIRM)
        |=> (!arr_start && status[5:4] == 2'b11 && rd_src == RD_STATUS));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_stb && cmd == CMD_CLR_STAT)
        |=> (status[5:4] == 2'b00 && $stable(rd_src)));
    p_hold_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_hold) |-> $past(wr_stb && cmd == CMD_SUSPEND));
    p_no_done_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_done |-> !arr_hold);
    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_stb && !idle_cmd_known(cmd))
        |=> (state == ST_IDLE && !arr_start && $stable(rd_src) && $stable(status)));

endmodule

// File: rtl/fcc_read_mux.sv
module fcc_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int          AW     = 16,
    parameter logic [15:0] MFG_ID = 16'h00A7,
    parameter logic [15:0] DEV_ID = 16'h3C19
) (
    input  logic          rd_en,
    input  rd_src_t       rd_src,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    status,
    input  logic [15:0]   arr_rdata,
    output logic [15:0]   rdata
);
    localparam logic [AW-1:0] ID_MFG_ADDR = AW'(0);
    localparam logic [AW-1:0] ID_DEV_ADDR = AW'(1);

    logic [15:0] id_word;

    always_comb begin
        if (rd_addr == ID_MFG_ADDR)      id_word = MFG_ID;
        else if (rd_addr == ID_DEV_ADDR) id_word = DEV_ID;
        else                             id_word = '0;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (rd_src)
                RD_ARRAY:  rdata = arr_rdata;
                RD_ID:     rdata = id_word;
                RD_STATUS: rdata = {8'h00, status};
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int          AW          = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] MFG_ID      = 16'h00A7,
    parameter logic [15:0] DEV_ID      = 16'h3C19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    output logic [AW-1:0] arr_raddr,
    input  logic [15:0]   arr_rdata,
    output logic          arr_start,
    output logic          arr_erase,
    output logic [AW-1:0] arr_addr,
    output logic [15:0]   arr_wdata,
    output logic          arr_hold,
    input  logic          arr_done
);
    logic          wr_stb, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [15:0]   wr_data;
    rd_src_t       rd_src;
    logic [7:0]    status;

    fcc_bus_sync #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr)
    );

    fcc_ctrl_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .arr_done(arr_done), .rd_src(rd_src), .status(status),
        .arr_start(arr_start), .arr_erase(arr_erase), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_hold(arr_hold)
    );

    fcc_read_mux #(.AW(AW), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_rmux (
        .rd_en(rd_en), .rd_src(rd_src), .rd_addr(rd_addr), .status(status),
        .arr_rdata(arr_rdata), .rdata(rdata)
    );

    assign arr_raddr = rd_addr;

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
    localparam int          AW  = 12;
    localparam logic [15:0] MFG = 16'h1C2D;
    localparam logic [15:0] DEV = 16'h7E51;
    localparam int          OPC = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata, arr_rdata, arr_wdata;
    logic [AW-1:0] arr_raddr, arr_addr;
    logic          arr_start, arr_erase, arr_hold;
    logic          arr_done = 1'b0;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(.AW(AW), .SYNC_STAGES(2), .MFG_ID(MFG), .DEV_ID(DEV)) u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .arr_raddr(arr_raddr),
        .arr_rdata(arr_rdata), .arr_start(arr_start), .arr_erase(arr_erase),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_hold(arr_hold),
        .arr_done(arr_done)
    );

    // array stub
    function automatic logic [15:0] arr_word(input logic [AW-1:0] a);
        return 16'hA000 ^ {4'h0, a};
    endfunction
    assign arr_rdata = arr_word(arr_raddr);

    int            cnt = 0, n_start = 0;
    logic          last_erase = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [15:0]   last_wdata = '0;

    always @(posedge clk) begin
        arr_done <= 1'b0;
        if (arr_start) begin
            cnt        <= OPC;
            n_start    <= n_start + 1;
            last_erase <= arr_erase;
            last_addr  <= arr_addr;
            last_wdata <= arr_wdata;
        end else if (cnt > 0 && !arr_hold) begin
            if (cnt == 1) arr_done <= 1'b1;
            cnt <= cnt - 1;
        end
    end

    // scoreboard
    logic [15:0] exp_q [$];
    string       tag_q [$];
    bit          samp_req = 0;

    always begin
        @(posedge clk);
        #1;
        if (samp_req && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d,
                             input bit ce_first = 0, input bit oe_low = 0);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 0; we_n = 0; oe_n = oe_low ? 1'b0 : 1'b1;
        repeat (3) @(negedge clk);
        if (ce_first) begin
            ce_n = 1;
            @(negedge clk);
            wdata = 16'h00FF; addr = '0;
            @(negedge clk);
            we_n = 1;
        end else begin
            we_n = 1;
            @(negedge clk);
            ce_n = 1;
        end
        oe_n = 1;
        repeat (6) @(negedge clk);
    endtask

    task automatic read_expect(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        addr = a; ce_n = 0; oe_n = 0; we_n = 1;
        repeat (4) @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        samp_req = 1;
        @(posedge clk);
        #3;
        samp_req = 0;
        @(negedge clk);
        ce_n = 1; oe_n = 1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        chk(rdata == 16'h0 && !arr_hold && !arr_start, "R1 reset outputs", {rdata, 7'b0, arr_hold, 7'b0, arr_start}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        read_expect(12'h005, arr_word(12'h005), "R1 default array read");
        bus_write(12'h000, 16'h0070);
        read_expect(12'h000, 16'h0080, "R1 R5 reset status");

        bus_write(12'h000, 16'h00FF);
        read_expect(12'h123, arr_word(12'h123), "R3 array read");

        bus_write(12'h000, 16'h0090);
        read_expect(12'h000, MFG, "R4 mfg id");
        read_expect(12'h001, DEV, "R4 dev id");
        read_expect(12'h002, 16'h0000, "R4 other id addr");

        bus_write(12'h000, 16'h0033);
        read_expect(12'h001, DEV, "R11 reserved ignored");
        chk(n_start == 0, "R11 no start", n_start, 0);

        bus_write(12'h000, 16'h00FF, 0, 1);
        read_expect(12'h000, MFG, "R2 oe overlap ignored");

        bus_write(12'h000, 16'h00FF);
        bus_write(12'h000, 16'h0090, 1, 0);
        read_expect(12'h001, DEV, "R2 ce first capture");

        bus_write(12'h000, 16'h0020);
        bus_write(12'h010, 16'h0033);
        chk(n_start == 0, "R9 no start on abort", n_start, 0);
        read_expect(12'h000, 16'h00B0, "R9 sequence error status");
        bus_write(12'h000, 16'h0050);
        read_expect(12'h000, 16'h0080, "R6 clear in status mode");
        bus_write(12'h000, 16'h0020);
        bus_write(12'h010, 16'h0055);
        bus_write(12'h000, 16'h00FF);
        bus_write(12'h000, 16'h0050);
        read_expect(12'h007, arr_word(12'h007), "R6 source unchanged");
        bus_write(12'h000, 16'h0070);
        read_expect(12'h000, 16'h0080, "R6 bits cleared");

        // erase with suspend/resume
        s0 = n_start;
        bus_write(12'h000, 16'h0020);
        bus_write(12'h345, 16'h00D0);
        chk(n_start == s0 + 1 && last_erase && last_addr == 12'h345, "R7 erase start",
            {last_erase, 19'b0, last_addr}, {1'b1, 19'b0, 12'h345});
        read_expect(12'h000, 16'h0000, "R7 busy status");
        bus_write(12'h000, 16'h00B0);
        chk(arr_hold == 1'b1, "R10 hold raised", arr_hold, 1);
        read_expect(12'h000, 16'h00C0, "R10 erase suspended status");
        bus_write(12'h000, 16'h00FF);
        read_expect(12'h009, arr_word(12'h009), "R10 array read while suspended");
        bus_write(12'h000, 16'h00D0);
        chk(arr_hold == 1'b0, "R10 hold released", arr_hold, 0);
        read_expect(12'h000, 16'h0000, "R10 resumed busy");
        repeat (80) @(negedge clk);
        read_expect(12'h000, 16'h0080, "R12 done ready");

        // program with suspend/resume
        s0 = n_start;
        bus_write(12'h000, 16'h0040);
        bus_write(12'h0AB, 16'hBEEF);
        chk(n_start == s0 + 1 && !last_erase && last_addr == 12'h0AB && last_wdata == 16'hBEEF,
            "R8 program start", {last_wdata, 4'b0, last_addr}, {16'hBEEF, 4'b0, 12'h0AB});
        read_expect(12'h000, 16'h0000, "R8 busy status");
        bus_write(12'h000, 16'h00B0);
        read_expect(12'h000, 16'h0084, "R10 program suspended status");
        bus_write(12'h000, 16'h00D0);
        repeat (80) @(negedge clk);
        read_expect(12'h000, 16'h0080, "R12 program done");

        s0 = n_start;
        bus_write(12'h000, 16'h0010);
        bus_write(12'h0CD, 16'h1234);
        chk(n_start == s0 + 1 && !last_erase && last_addr == 12'h0CD && last_wdata == 16'h1234,
            "R8 alt opener", {last_wdata, 4'b0, last_addr}, {16'h1234, 4'b0, 12'h0CD});
        repeat (80) @(negedge clk);
        read_expect(12'h000, 16'h0080, "R12 alt done");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule